// File: doc/BRIEF.md
# Round-Robin Sample Capture Sequencer

This block runs a fixed sampling loop over eight analog channels. It asks an external converter for one conversion on the current channel and waits for that conversion to finish. It then turns the 12-bit result into two bytes and hands them, one at a time, to a byte-wide storage writer through a valid/ready handshake. Each byte carries a linear byte address. Once the second byte has been taken, the channel and the address move on and the next conversion is requested.

The storage address is kept as three chained fields: two low fields of `FIELD_W` bits and a high field of `HI_W` bits. With the defaults this gives a 23-bit byte address covering 8 MB. When the high field reaches `FULL_HI`, the sequencer stops for good. It raises `full` and starts no further conversions or writes until reset. If a conversion-done pulse arrives while the sequencer is not waiting for one, the sticky `overrun` flag is set and that result is discarded. The sample already in progress is never corrupted by it.

Top module: `adc_flash_seq`

## Requirements
- R1: While `rst_n` is low, `conv_chan`, `wr_addr`, `full` and `overrun` are zero and `conv_start` and `wr_valid` are low. After reset is released, `conv_start` first rises on the second clock, with `conv_chan` = 0.
- R2: Conversions are requested on channels 0, 1, …, 7 in turn, and the channel after 7 is 0. `conv_chan` shows the channel of the conversion being requested or awaited, and advances in the cycle after a low byte is accepted.
- R3: `conv_start` is a one-cycle pulse. A `conv_done` that arrives while a conversion is awaited makes `wr_valid` rise in the next cycle. The next `conv_start` comes in the cycle right after the low byte is accepted, so only one sample is ever in flight.
- R4: The first byte offered for a sample is result bits 11:4. The second byte is result bits 3:0 in bits 7:4, with bits 3:0 zero.
- R5: `wr_addr` is the linear byte address `hi·2^(2·FIELD_W) + mid·2^FIELD_W + lo`. It rises by exactly one in the cycle after each accepted byte (`wr_valid` and `wr_ready` both high) and holds otherwise. A low field that passes its maximum wraps to zero and carries into the field above.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_byte` and `wr_addr` hold their values, and no byte of the sample is lost.
- R7: When a low byte is accepted and the high address field becomes `FULL_HI`, `full` rises in the next cycle. It then stays high until reset. While `full` is high, `conv_start` and `wr_valid` stay low, and `conv_done` has no effect on any output.
- R8: A `conv_done` in any cycle where no conversion is awaited and `full` is low sets `overrun` in the next cycle, and `overrun` stays set until reset. The stray result is dropped: the bytes of the sample being written keep the values of the conversion that was awaited.
- R9: A reset in the middle of a run, including after `full`, clears the channel, address, `full` and `overrun`. Capture then starts again from channel 0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_chan | output | $clog2(NUM_CH) | Channel of the requested conversion |
| conv_done | input | 1 | One-cycle pulse when a conversion finishes |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |
| wr_valid | output | 1 | A byte is offered to the writer |
| wr_ready | input | 1 | The writer takes the offered byte this cycle |
| wr_byte | output | 8 | Byte offered to the writer |
| wr_addr | output | 2·FIELD_W+HI_W | Linear byte address of the offered byte |
| full | output | 1 | Address space used up; sequencer halted |
| overrun | output | 1 | Sticky: a result arrived when none was awaited |

## Verification
Every result of this block is registered once:
- The first byte appears one cycle after an awaited `conv_done`.
- The address step and the channel step appear one cycle after the accepting edge.
- The next `conv_start` or `full` appears one cycle after the low byte is taken.
- `overrun` appears one cycle after a stray pulse.

The bench drives inputs and samples outputs on the falling edge. It advances a behavioural reference model by exactly one rising edge between two samples, so each output is compared in the first cycle in which it is due. Converter latency and writer back-pressure are varied so that these one-cycle offsets are tested under stalls as well as under a writer that is always ready.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SAMPLE_W = 12;
  localparam int BYTE_W   = 8;
  localparam int PAIR_W   = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_LAUNCH,
    ST_WAIT,
    ST_HI,
    ST_LO,
    ST_HALT
  } seq_state_t;

  // Left-justify a sample into a two-byte word, zero-filling the tail.
  function automatic logic [PAIR_W-1:0] pack_pair(input logic [SAMPLE_W-1:0] s);
    return {s, {(PAIR_W - SAMPLE_W){1'b0}}};
  endfunction

  // Upper byte first, lower byte second.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [PAIR_W-1:0] p,
                                                  input logic second);
    return second ? p[BYTE_W-1:0] : p[PAIR_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/seq_chan_ctr.sv
module seq_chan_ctr #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [CH_W-1:0] chan
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (advance) begin
      chan_q <= (chan_q == LAST) ? '0 : chan_q + 1'b1;
    end
  end

  assign chan = chan_q;
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr #(
  parameter int FIELD_W   = 8,
  parameter int LO_FIELDS = 2,
  parameter int HI_W      = 7,
  localparam int ADDR_W   = LO_FIELDS * FIELD_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic [HI_W-1:0]   hi_next
);
  logic [LO_FIELDS:0] carry;
  logic [HI_W-1:0]    hi_q;

  assign carry[0] = inc;

  for (genvar g = 0; g < LO_FIELDS; g++) begin : g_field
    logic [FIELD_W-1:0] fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q <= '0;
      end else if (carry[g]) begin
        fld_q <= fld_q + 1'b1;
      end
    end
    assign carry[g+1] = carry[g] & (&fld_q);
    assign addr[g*FIELD_W +: FIELD_W] = fld_q;
  end

  assign hi_next = carry[LO_FIELDS] ? hi_q + 1'b1 : hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else begin
      hi_q <= hi_next;
    end
  end

  assign addr[ADDR_W-1 -: HI_W] = hi_q;
endmodule

// File: rtl/seq_byte_pack.sv
module seq_byte_pack
  import adc_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                second,
  output logic [BYTE_W-1:0]   byte_out
);
  logic [PAIR_W-1:0] pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else if (load) begin
      pair_q <= pack_pair(sample_in);
    end
  end

  assign byte_out = pick_byte(pair_q, second);
endmodule

// File: rtl/adc_flash_seq.sv
module adc_flash_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int FIELD_W = 8,
  parameter int HI_W    = 7,
  parameter int FULL_HI = 63,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LO_FIELDS = 2,
  localparam int ADDR_W    = LO_FIELDS * FIELD_W + HI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                conv_start,
  output logic [CH_W-1:0]     conv_chan,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_result,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [BYTE_W-1:0]   wr_byte,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic                full,
  output logic                overrun
);
  seq_state_t      state_q, state_d;
  logic [HI_W-1:0] hi_next;
  logic            overrun_q;

  // Named internal events, also observed by the bound checker.
  logic st_wait, evt_capture, evt_hi_acc, evt_lo_acc, evt_limit, evt_stray;

  assign st_wait     = (state_q == ST_WAIT);
  assign evt_capture = st_wait && conv_done;
  assign evt_hi_acc  = (state_q == ST_HI) && wr_ready;
  assign evt_lo_acc  = (state_q == ST_LO) && wr_ready;
  assign evt_limit   = evt_lo_acc && (hi_next == HI_W'(FULL_HI));
  assign evt_stray   = conv_done && !st_wait && (state_q != ST_HALT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:   state_d = ST_LAUNCH;
      ST_LAUNCH: state_d = ST_WAIT;
      ST_WAIT:   if (conv_done)  state_d = ST_HI;
      ST_HI:     if (wr_ready)   state_d = ST_LO;
      ST_LO:     if (evt_lo_acc) state_d = evt_limit ? ST_HALT : ST_LAUNCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INIT;
      overrun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (evt_stray) overrun_q <= 1'b1;
    end
  end

  seq_chan_ctr #(.NUM_CH(NUM_CH)) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (evt_lo_acc),
    .chan    (conv_chan)
  );

  seq_addr_ctr #(.FIELD_W(FIELD_W), .LO_FIELDS(LO_FIELDS), .HI_W(HI_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (evt_hi_acc || evt_lo_acc),
    .addr    (wr_addr),
    .hi_next (hi_next)
  );

  seq_byte_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (evt_capture),
    .sample_in (conv_result),
    .second    (state_q == ST_LO),
    .byte_out  (wr_byte)
  );

  assign conv_start = (state_q == ST_LAUNCH);
  assign wr_valid   = (state_q == ST_HI) || (state_q == ST_LO);
  assign full       = (state_q == ST_HALT);
  assign overrun    = overrun_q;
endmodule

// File: rtl/adc_flash_seq_chk.sv
module adc_flash_seq_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_done,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [7:0]        wr_byte,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              full,
  input logic              overrun,
  input logic              st_wait,
  input logic              evt_lo_acc,
  input logic              evt_limit,
  input logic              evt_stray
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (conv_chan == '0 && wr_addr == '0 && !full && !overrun && !conv_start && !wr_valid));

  assert_chan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lo_acc |=> conv_chan == (($past(conv_chan) == CH_W'(NUM_CH - 1)) ? '0 : $past(conv_chan) + 1'b1));

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_capture_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && conv_done) |=> wr_valid);

  assert_next_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lo_acc && !evt_limit) |=> conv_start);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> wr_addr == $past(wr_addr) + ADDR_W'(1));

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(wr_addr));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte)));

  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  assert_full_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!conv_start && !wr_valid));

  assert_limit_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_limit |=> full);

  assert_one_activity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, wr_valid, full}));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_stray_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stray |=> overrun);
endmodule

bind adc_flash_seq adc_flash_seq_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_byte    (wr_byte),
  .wr_addr    (wr_addr),
  .full       (full),
  .overrun    (overrun),
  .st_wait    (st_wait),
  .evt_lo_acc (evt_lo_acc),
  .evt_limit  (evt_limit),
  .evt_stray  (evt_stray)
);

// File: tb/adc_flash_seq_bench.sv
module adc_flash_seq_bench;
  localparam int NCH  = 8;
  localparam int FW   = 2;
  localparam int HW   = 2;
  localparam int FULL = 2;
  localparam int AW   = 2 * FW + HW;

  localparam int S_INIT = 0, S_LAUNCH = 1, S_WAIT = 2, S_HI = 3, S_LO = 4, S_HALT = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_done = 1'b0;
  logic [11:0]   conv_result = '0;
  logic          wr_ready = 1'b0;
  logic          conv_start, wr_valid, full, overrun;
  logic [2:0]    conv_chan;
  logic [7:0]    wr_byte;
  logic [AW-1:0] wr_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Reference model state
  int m_st, m_chan, m_addr, m_sample, m_ovr, m_samples, adc_cnt, inj_last;
  bit prev_stall;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  adc_flash_seq #(.NUM_CH(NCH), .FIELD_W(FW), .HI_W(HW), .FULL_HI(FULL)) u_adc_flash_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_byte     (wr_byte),
    .wr_addr     (wr_addr),
    .full        (full),
    .overrun     (overrun)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_init();
    m_st = S_INIT; m_chan = 0; m_addr = 0; m_sample = 0; m_ovr = 0;
    m_samples = 0; adc_cnt = 0; inj_last = -1; prev_stall = 1'b0;
  endtask

  task automatic compare_all();
    int exp_byte;
    check("R3 conv_start", int'(conv_start), int'(m_st == S_LAUNCH));
    check("R2 conv_chan", int'(conv_chan), m_chan);
    check("R3 wr_valid", int'(wr_valid), int'(m_st == S_HI || m_st == S_LO));
    if (m_st == S_HI || m_st == S_LO) begin
      exp_byte = (m_st == S_HI) ? ((m_sample >> 4) & 8'hFF) : ((m_sample & 4'hF) << 4);
      check(prev_stall ? "R6 held byte" : "R4 byte value", int'(wr_byte), exp_byte);
    end
    check(prev_stall ? "R6 held address" : "R5 address", int'(wr_addr), m_addr);
    check("R7 full", int'(full), int'(m_st == S_HALT));
    check("R8 overrun", int'(overrun), m_ovr);
  endtask

  // Apply inputs for one cycle, advance the model by one rising edge, resample.
  task automatic step(input bit done, input int data, input bit rdy);
    conv_done   = done;
    conv_result = 12'(data);
    wr_ready    = rdy;
    prev_stall  = (m_st == S_HI || m_st == S_LO) && !rdy;
    if (done && m_st != S_WAIT && m_st != S_HALT) m_ovr = 1;
    case (m_st)
      S_INIT:   m_st = S_LAUNCH;
      S_LAUNCH: m_st = S_WAIT;
      S_WAIT:   if (done) begin m_sample = data & 12'hFFF; m_st = S_HI; end
      S_HI:     if (rdy) begin m_addr++; m_st = S_LO; end
      S_LO:     if (rdy) begin
                  m_addr++;
                  m_chan = (m_chan + 1) % NCH;
                  m_samples++;
                  m_st = ((m_addr >> (2 * FW)) == FULL) ? S_HALT : S_LAUNCH;
                end
      default:  m_st = m_st;
    endcase
    @(negedge clk);
  endtask

  task automatic run_cycle(input int mode);
    bit d;
    int dat;
    bit r;
    logic [31:0] x;
    x = rnd();
    d = 1'b0;
    dat = 0;
    if (m_st == S_LAUNCH) adc_cnt = 1 + int'(x[3:0] % 4);
    if (m_st == S_WAIT) begin
      if (adc_cnt == 0) begin d = 1'b1; dat = int'(x[27:16]); end
      else adc_cnt--;
    end
    // R8: stray result while the high byte of a sample is on offer
    if (m_st == S_HI && (m_samples == 5 || m_samples == 12) && inj_last != m_samples) begin
      d = 1'b1; dat = 12'hABC; inj_last = m_samples;
    end
    case (mode)
      0:       r = 1'b1;
      1:       r = x[8];
      default: r = (x[10:9] == 2'b00);
    endcase
    step(d, dat, r);
  endtask

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    // R1: values held under reset
    check("R1 reset conv_start", int'(conv_start), 0);
    check("R1 reset wr_valid", int'(wr_valid), 0);
    check("R1 reset conv_chan", int'(conv_chan), 0);
    check("R1 reset wr_addr", int'(wr_addr), 0);
    check("R1 reset full", int'(full), 0);
    check("R1 reset overrun", int'(overrun), 0);
    rst_n = 1'b1;
    check("R1 no start in first cycle", int'(conv_start), 0);
    compare_all();
    step(1'b0, 0, 1'b0);
    check("R1 first start", int'(conv_start), 1);
    check("R1 first channel", int'(conv_chan), 0);

    while (m_st != S_HALT) begin
      compare_all();
      run_cycle((m_samples < 4) ? 0 : (m_samples < 10) ? 1 : 2);
    end
    compare_all();
    check("R7 halt address", int'(wr_addr), 32);
    check("R2 channel after two laps", int'(conv_chan), 0);
    check("R8 overrun after strays", int'(overrun), 1);

    // R7: after halting, conversion-done pulses and ready changes do nothing
    for (int i = 0; i < 30; i++) begin
      logic [31:0] y;
      y = rnd();
      step(y[0], int'(y[15:4]), y[1]);
      compare_all();
    end

    // R9: reset after halting restarts from zero
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 full cleared", int'(full), 0);
    check("R9 overrun cleared", int'(overrun), 0);
    check("R9 address cleared", int'(wr_addr), 0);
    check("R9 channel cleared", int'(conv_chan), 0);
    rst_n = 1'b1;
    model_init();
    while (m_samples < 3) begin
      compare_all();
      run_cycle(0);
    end
    compare_all();
    check("R9 restarted address", int'(wr_addr), 6);
    check("R9 restarted channel", int'(conv_chan), 3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule